// File: doc/BRIEF.md
# Display Native Mode Selector

This block takes the decoded detailed-timing descriptors of one display identification record as a stream of beats, one descriptor per cycle in which `beat_valid` is high. From them it picks the display's native mode and turns that mode into modeline numbers. The numbers are the scaled pixel clock, the display size, the sync edges and the totals for each axis, and a small flag word. Raw byte parsing, checksums and aspect ratio are handled elsewhere. The block only sees descriptors that are already split into fields.

A record starts with a `start` pulse, which drops whatever mode was kept from earlier beats. The descriptor marked `beat_last` closes the record. One cycle later the registered outputs show the result. They keep that value until the next closing beat. Each descriptor is judged on its horizontal active size alone. A descriptor counts only if it is marked as a timing descriptor and has a non-zero clock. A mode smaller than 640 by 480 is not reported.

Top module: `native_mode_picker`

## Requirements
- R1: A beat is a candidate only when `d_is_timing` is 1 and `d_pclk` is non-zero. Any other beat never changes the selection.
- R2: A candidate replaces the kept mode only when its horizontal active size is strictly larger than the kept one. A tie keeps the earlier descriptor, and vertical size plays no part in the choice.
- R3: For each axis the block reports: display = active, sync start = active + sync offset, sync end = sync start + sync width, total = active + blank. All are computed without overflow at 14 bits.
- R4: `pix_clk` equals the selected descriptor's clock multiplied by 10.
- R5: `flags` bit 0 (positive horizontal sync) copies misc bit 0, and bit 1 (positive vertical sync) copies misc bit 1. Both are set only when the sync type code equals 3. Bit 2 copies the interlace flag whatever the sync type.
- R6: `mode_valid` is 0 when no mode was selected, when the horizontal display is below 640, or when the vertical display is below 480. While `mode_valid` is 0, every other output is 0.
- R7: `digital` equals the `rec_digital` value presented with the closing beat, and only when `mode_valid` is 1.
- R8: All outputs update one cycle after a beat with `beat_valid` and `beat_last` both high, and that beat takes part in the choice. At every other time they hold.
- R9: `start` empties the selection. A beat in the same cycle as `start` is judged against the empty selection. Without `start`, the selection carries over from the previous record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Clears the selection for a new record |
| beat_valid | input | 1 | A descriptor is presented this cycle |
| beat_last | input | 1 | This descriptor closes the record |
| d_is_timing | input | 1 | Descriptor is a detailed timing |
| d_pclk | input | 16 | Pixel clock in 10 kHz units |
| d_h_act | input | 12 | Horizontal active |
| d_h_blank | input | 12 | Horizontal blanking |
| d_h_soff | input | 12 | Horizontal sync offset |
| d_h_swid | input | 12 | Horizontal sync width |
| d_v_act | input | 12 | Vertical active |
| d_v_blank | input | 12 | Vertical blanking |
| d_v_soff | input | 12 | Vertical sync offset |
| d_v_swid | input | 12 | Vertical sync width |
| d_sync_kind | input | 2 | Sync type code |
| d_pol | input | 2 | Misc polarity bits |
| d_ilace | input | 1 | Interlace flag |
| rec_digital | input | 1 | Record's digital-input bit, taken with the closing beat |
| pix_clk | output | 20 | Pixel clock in kHz |
| h_disp | output | 14 | Horizontal display |
| h_sstart | output | 14 | Horizontal sync start |
| h_send | output | 14 | Horizontal sync end |
| h_total | output | 14 | Horizontal total |
| v_disp | output | 14 | Vertical display |
| v_sstart | output | 14 | Vertical sync start |
| v_send | output | 14 | Vertical sync end |
| v_total | output | 14 | Vertical total |
| flags | output | 3 | {interlace, vsync positive, hsync positive} |
| digital | output | 1 | Digital input, only with a valid mode |
| mode_valid | output | 1 | A qualifying native mode is reported |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is clearing the selection and judging a descriptor. The bench raises `start` together with a closing beat whose width is smaller than the mode kept from the record before. The result must show the smaller mode, not the old one. The second pair is judging a descriptor and publishing the result. The widest descriptor of several records is placed on the closing beat itself, and the output one cycle later must already show it.

// File: rtl/nmp_pkg.sv
package nmp_pkg;
   localparam int AXW = 12;
   localparam int PCW = 16;
   localparam int OW  = AXW + 2;
   localparam int PXW = PCW + 4;

   localparam int FLG_HPOS  = 0;
   localparam int FLG_VPOS  = 1;
   localparam int FLG_ILACE = 2;
   localparam int FLW       = 3;

   typedef struct packed {
      logic [AXW-1:0] act;
      logic [AXW-1:0] blank;
      logic [AXW-1:0] soff;
      logic [AXW-1:0] swid;
   } axis_t;

   typedef struct packed {
      logic [PCW-1:0] pclk;
      axis_t          h;
      axis_t          v;
      logic [1:0]     sync_kind;
      logic [1:0]     pol;
      logic           ilace;
   } desc_t;

   typedef struct packed {
      logic [OW-1:0] disp;
      logic [OW-1:0] sstart;
      logic [OW-1:0] send;
      logic [OW-1:0] total;
   } axis_out_t;
endpackage

// File: rtl/nmp_pick.sv
module nmp_pick
   import nmp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  beat_valid,
   input  logic  is_timing,
   input  desc_t din,
   output desc_t sel_nxt
);
   desc_t          best_q;
   logic [AXW-1:0] base_act;
   logic           take;

   assign base_act = start ? '0 : best_q.h.act;
   assign take     = beat_valid && is_timing && (din.pclk != '0)
                     && (din.h.act > base_act);

   always_comb begin
      if (take)       sel_nxt = din;
      else if (start) sel_nxt = '0;
      else            sel_nxt = best_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) best_q <= '0;
      else        best_q <= sel_nxt;
   end

   // R2
   widest_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> best_q.h.act >= $past(best_q.h.act));

   // R9
   start_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !beat_valid) |=> best_q.h.act == '0);
endmodule

// File: rtl/nmp_axis.sv
module nmp_axis
   import nmp_pkg::*;
(
   input  axis_t     ain,
   output axis_out_t aout
);
   logic [OW-1:0] act_w;

   assign act_w       = OW'(ain.act);
   assign aout.disp   = act_w;
   assign aout.sstart = act_w + OW'(ain.soff);
   assign aout.send   = aout.sstart + OW'(ain.swid);
   assign aout.total  = act_w + OW'(ain.blank);
endmodule

// File: rtl/nmp_result.sv
module nmp_result
   import nmp_pkg::*;
#(
   parameter int MIN_H       = 640,
   parameter int MIN_V       = 480,
   parameter bit CHECK_FLOOR = 1'b1,
   parameter int PCLK_SCALE  = 10,
   parameter int POL_CODE    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [PCW-1:0]       pclk,
   input  logic [1:0]           sync_kind,
   input  logic [1:0]           pol,
   input  logic                 ilace,
   input  logic                 rec_digital,
   input  axis_out_t [1:0]      axo,
   output logic [PXW-1:0]       pix_clk,
   output axis_out_t [1:0]      ax_q,
   output logic [FLW-1:0]       flags,
   output logic                 digital,
   output logic                 mode_valid
);
   logic [PXW-1:0] pix_w;
   logic           found, big_enough, ok;
   logic [FLW-1:0] flg_w;

   generate
      if (PCLK_SCALE == 10) begin : g_shift_add
         assign pix_w = (PXW'(pclk) << 3) + (PXW'(pclk) << 1);
      end else begin : g_mult
         assign pix_w = PXW'(pclk) * PXW'(PCLK_SCALE);
      end
      if (CHECK_FLOOR) begin : g_floor
         assign big_enough = (axo[0].disp >= OW'(MIN_H)) && (axo[1].disp >= OW'(MIN_V));
      end else begin : g_no_floor
         assign big_enough = 1'b1;
      end
   endgenerate

   assign found = (axo[0].disp != '0) && (axo[1].disp != '0);
   assign ok    = found && big_enough;

   always_comb begin
      flg_w            = '0;
      flg_w[FLG_HPOS]  = (sync_kind == 2'(POL_CODE)) && pol[0];
      flg_w[FLG_VPOS]  = (sync_kind == 2'(POL_CODE)) && pol[1];
      flg_w[FLG_ILACE] = ilace;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_clk    <= '0;
         ax_q       <= '0;
         flags      <= '0;
         digital    <= 1'b0;
         mode_valid <= 1'b0;
      end else if (load) begin
         pix_clk    <= ok ? pix_w : '0;
         ax_q       <= ok ? axo : '0;
         flags      <= ok ? flg_w : '0;
         digital    <= ok && rec_digital;
         mode_valid <= ok;
      end
   end

   // R3
   sync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_valid |-> (ax_q[0].sstart >= ax_q[0].disp) && (ax_q[0].send >= ax_q[0].sstart)
                  && (ax_q[1].sstart >= ax_q[1].disp) && (ax_q[1].send >= ax_q[1].sstart)
                  && (ax_q[0].total >= ax_q[0].disp) && (ax_q[1].total >= ax_q[1].disp));

   // R6
   floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_valid && CHECK_FLOOR) |-> (ax_q[0].disp >= OW'(MIN_H)) && (ax_q[1].disp >= OW'(MIN_V)));

   // R6
   invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_valid |-> (pix_clk == '0) && (flags == '0) && !digital && (ax_q == '0));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(pix_clk) && $stable(mode_valid) && $stable(flags) && $stable(ax_q));

   // R7
   digital_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      digital |-> mode_valid);
endmodule

// File: rtl/native_mode_picker.sv
module native_mode_picker
   import nmp_pkg::*;
#(
   parameter int MIN_H       = 640,
   parameter int MIN_V       = 480,
   parameter bit CHECK_FLOOR = 1'b1,
   parameter int PCLK_SCALE  = 10,
   parameter int POL_CODE    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              beat_valid,
   input  logic              beat_last,
   input  logic              d_is_timing,
   input  logic [15:0]       d_pclk,
   input  logic [11:0]       d_h_act,
   input  logic [11:0]       d_h_blank,
   input  logic [11:0]       d_h_soff,
   input  logic [11:0]       d_h_swid,
   input  logic [11:0]       d_v_act,
   input  logic [11:0]       d_v_blank,
   input  logic [11:0]       d_v_soff,
   input  logic [11:0]       d_v_swid,
   input  logic [1:0]        d_sync_kind,
   input  logic [1:0]        d_pol,
   input  logic              d_ilace,
   input  logic              rec_digital,
   output logic [19:0]       pix_clk,
   output logic [13:0]       h_disp,
   output logic [13:0]       h_sstart,
   output logic [13:0]       h_send,
   output logic [13:0]       h_total,
   output logic [13:0]       v_disp,
   output logic [13:0]       v_sstart,
   output logic [13:0]       v_send,
   output logic [13:0]       v_total,
   output logic [2:0]        flags,
   output logic              digital,
   output logic              mode_valid
);
   generate
      if (MIN_H < 1 || MIN_H >= (1 << AXW)) begin : g_bad_min_h
         $error("MIN_H out of range for the axis width");
      end
      if (MIN_V < 1 || MIN_V >= (1 << AXW)) begin : g_bad_min_v
         $error("MIN_V out of range for the axis width");
      end
      if (PCLK_SCALE < 1 || PCLK_SCALE > 15) begin : g_bad_scale
         $error("PCLK_SCALE must fit the four spare output bits");
      end
      if (POL_CODE < 0 || POL_CODE > 3) begin : g_bad_code
         $error("POL_CODE must be a two-bit code");
      end
   endgenerate

   desc_t            din, sel_nxt;
   axis_t     [1:0]  ax_in;
   axis_out_t [1:0]  ax_calc, ax_q;

   assign din.pclk      = d_pclk;
   assign din.h         = '{act: d_h_act, blank: d_h_blank, soff: d_h_soff, swid: d_h_swid};
   assign din.v         = '{act: d_v_act, blank: d_v_blank, soff: d_v_soff, swid: d_v_swid};
   assign din.sync_kind = d_sync_kind;
   assign din.pol       = d_pol;
   assign din.ilace     = d_ilace;

   nmp_pick u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .beat_valid(beat_valid),
      .is_timing (d_is_timing),
      .din       (din),
      .sel_nxt   (sel_nxt)
   );

   assign ax_in[0] = sel_nxt.h;
   assign ax_in[1] = sel_nxt.v;

   generate
      for (genvar a = 0; a < 2; a++) begin : g_axis
         nmp_axis u_axis (.ain(ax_in[a]), .aout(ax_calc[a]));
      end
   endgenerate

   nmp_result #(
      .MIN_H      (MIN_H),
      .MIN_V      (MIN_V),
      .CHECK_FLOOR(CHECK_FLOOR),
      .PCLK_SCALE (PCLK_SCALE),
      .POL_CODE   (POL_CODE)
   ) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (beat_valid && beat_last),
      .pclk       (sel_nxt.pclk),
      .sync_kind  (sel_nxt.sync_kind),
      .pol        (sel_nxt.pol),
      .ilace      (sel_nxt.ilace),
      .rec_digital(rec_digital),
      .axo        (ax_calc),
      .pix_clk    (pix_clk),
      .ax_q       (ax_q),
      .flags      (flags),
      .digital    (digital),
      .mode_valid (mode_valid)
   );

   assign h_disp   = ax_q[0].disp;
   assign h_sstart = ax_q[0].sstart;
   assign h_send   = ax_q[0].send;
   assign h_total  = ax_q[0].total;
   assign v_disp   = ax_q[1].disp;
   assign v_sstart = ax_q[1].sstart;
   assign v_send   = ax_q[1].send;
   assign v_total  = ax_q[1].total;
endmodule

// File: tb/sim_native_mode_picker.sv
module sim_native_mode_picker;
   localparam int HALF = 10;

   typedef struct packed {
      bit        last;
      bit        dig;
      bit        ist;
      bit [15:0] pclk;
      bit [11:0] ha, hb, hso, hsw;
      bit [11:0] va, vb, vso, vsw;
      bit [1:0]  st;
      bit [1:0]  misc;
      bit        il;
      bit        ev;
      bit [11:0] eh;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      // record A: R2 R3 R4 R5
      '{0,0,1, 6500, 1024,320,24,136,  768,38,3,6,  3,1,0, 0,0},
      '{1,1,1,10800, 1280,408,48,112, 1024,42,1,3,  3,3,0, 1,1280},
      // record B: R1 and the exact 640x480 floor
      '{0,0,0,14850, 1920,280,88,44,  1080,45,4,5,  3,3,0, 0,0},
      '{0,0,1,    0, 1680,160,48,32,  1050,30,3,6,  3,3,0, 0,0},
      '{1,0,1, 2517,  640,160,16,96,   480,45,10,2, 2,3,0, 1,640},
      // record C: R2 tie and vertical ignored
      '{0,0,1, 4000,  800,256,40,128,  600,28,1,4,  3,2,0, 0,0},
      '{0,0,1, 5000,  800,100,10,10,  1200,50,5,5,  3,1,0, 0,0},
      '{1,0,1, 6000,  720,100,10,10,  2000,50,5,5,  3,1,0, 1,800},
      // record D/E/F: R6 R7
      '{1,1,1, 5000,  639,100,10,10,  1000,50,5,5,  3,3,0, 0,0},
      '{1,1,1, 5000, 1000,100,10,10,   479,50,5,5,  3,3,1, 0,0},
      '{1,1,0, 5000, 1000,100,10,10,   800,50,5,5,  3,3,0, 0,0},
      // record G: four beats, widest first, R5 interlace with other sync type
      '{0,0,1,14850, 1920,280,88,44,  1080,22,2,5,  1,3,1, 0,0},
      '{0,0,1,13000, 1600,200,40,40,  1200,30,3,3,  3,3,0, 0,0},
      '{0,0,1,10800, 1280,408,48,112, 1024,42,1,3,  3,3,0, 0,0},
      '{1,1,1,20000, 1920,300,90,50,  1200,30,3,3,  3,3,0, 1,1920},
      // record H: widest values, R3 R4 overflow
      '{1,1,1,65535, 4095,4095,4095,4095, 4095,4095,4095,4095, 3,3,1, 1,4095}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, beat_valid = 1'b0, beat_last = 1'b0;
   logic d_is_timing = 1'b0, d_ilace = 1'b0, rec_digital = 1'b0;
   logic [15:0] d_pclk = '0;
   logic [11:0] d_h_act = '0, d_h_blank = '0, d_h_soff = '0, d_h_swid = '0;
   logic [11:0] d_v_act = '0, d_v_blank = '0, d_v_soff = '0, d_v_swid = '0;
   logic [1:0]  d_sync_kind = '0, d_pol = '0;
   logic [19:0] pix_clk;
   logic [13:0] h_disp, h_sstart, h_send, h_total, v_disp, v_sstart, v_send, v_total;
   logic [2:0]  flags;
   logic        digital, mode_valid;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   vec_t mb = '0;

   always #HALF clk = ~clk;

   native_mode_picker u0 (.*);

   task automatic chk(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic put(vec_t r, bit with_start);
      if (with_start) mb = '0;
      start       = with_start;
      beat_valid  = 1'b1;
      beat_last   = r.last;
      d_is_timing = r.ist;
      d_pclk      = r.pclk;
      d_h_act = r.ha; d_h_blank = r.hb; d_h_soff = r.hso; d_h_swid = r.hsw;
      d_v_act = r.va; d_v_blank = r.vb; d_v_soff = r.vso; d_v_swid = r.vsw;
      d_sync_kind = r.st; d_pol = r.misc; d_ilace = r.il;
      rec_digital = r.dig;
      if (r.ist && r.pclk != 0 && r.ha > mb.ha) mb = r;
      @(negedge clk);
      start = 1'b0; beat_valid = 1'b0; beat_last = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1; mb = '0;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic check_all(vec_t r);
      bit ok;
      ok = (mb.ha != 0) && (mb.va != 0) && (mb.ha >= 640) && (mb.va >= 480);
      chk("R6", "valid model", int'(mode_valid), int'(ok));
      chk("R6", "valid table", int'(mode_valid), int'(r.ev));
      if (r.ev) chk("R2", "table width", int'(h_disp), int'(r.eh));
      chk("R4", "pix_clk", int'(pix_clk), ok ? int'(mb.pclk) * 10 : 0);
      chk("R3", "h_disp", int'(h_disp), ok ? int'(mb.ha) : 0);
      chk("R3", "h_sstart", int'(h_sstart), ok ? int'(mb.ha) + int'(mb.hso) : 0);
      chk("R3", "h_send", int'(h_send), ok ? int'(mb.ha) + int'(mb.hso) + int'(mb.hsw) : 0);
      chk("R3", "h_total", int'(h_total), ok ? int'(mb.ha) + int'(mb.hb) : 0);
      chk("R3", "v_disp", int'(v_disp), ok ? int'(mb.va) : 0);
      chk("R3", "v_sstart", int'(v_sstart), ok ? int'(mb.va) + int'(mb.vso) : 0);
      chk("R3", "v_send", int'(v_send), ok ? int'(mb.va) + int'(mb.vso) + int'(mb.vsw) : 0);
      chk("R3", "v_total", int'(v_total), ok ? int'(mb.va) + int'(mb.vb) : 0);
      chk("R5", "flags", int'(flags), ok ? int'({mb.il, mb.st == 2'd3 && mb.misc[1],
                                                  mb.st == 2'd3 && mb.misc[0]}) : 0);
      chk("R7", "digital", int'(digital), int'(ok && r.dig));
   endtask

   initial begin
      #(2 * HALF * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      vec_t w;
      bit fresh;
      repeat (3) @(negedge clk);
      // reset state, R6
      chk("R6", "reset valid", int'(mode_valid), 0);
      chk("R6", "reset pix", int'(pix_clk), 0);
      chk("R7", "reset digital", int'(digital), 0);
      rst_n = 1'b1;
      @(negedge clk);

      fresh = 1;
      for (int i = 0; i < NV; i++) begin
         if (fresh) pulse_start();
         put(TBL[i], 1'b0);
         if (TBL[i].last) check_all(TBL[i]);
         fresh = TBL[i].last;
      end

      // R9: selection persists without start
      pulse_start();
      w = '{1,0,1, 10000, 1280,100,10,10, 1024,20,2,2, 0,0,0, 1,1280};
      put(w, 1'b0); check_all(w);
      w = '{1,0,1, 9000, 1024,100,10,10, 768,20,2,2, 0,0,0, 1,1280};
      put(w, 1'b0); check_all(w);
      chk("R9", "carry-over width", int'(h_disp), 1280);

      // R9: start in the same cycle as the closing beat
      w = '{1,1,1, 4000, 800,100,10,10, 600,20,2,2, 3,1,0, 1,800};
      put(w, 1'b1); check_all(w);
      chk("R9", "same-cycle start width", int'(h_disp), 800);

      // R8: non-closing beat and bare start leave outputs alone
      w = '{0,0,1, 14850, 1920,280,88,44, 1080,45,4,5, 3,3,1, 0,0};
      put(w, 1'b0);
      chk("R8", "hold after non-last beat", int'(h_disp), 800);
      pulse_start();
      chk("R8", "hold after start", int'(mode_valid), 1);
      chk("R8", "hold pix", int'(pix_clk), 40000);
      // R1: closing beat that is not a timing leaves empty selection
      w = '{1,1,0, 14850, 1920,280,88,44, 1080,45,4,5, 3,3,1, 0,0};
      put(w, 1'b0); check_all(w);
      chk("R1", "non-timing closing beat", int'(mode_valid), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule